// File: doc/BRIEF.md
# Full-Duplex Serial Port with 7/8/9-Bit Frames

This block is an asynchronous serial port with two independent halves. The transmitter turns host words into frames on a single line, and the receiver rebuilds words from frames arriving on another line. Both halves can be active in the same cycle. A 2-bit length code selects 7, 8 or 9 data bits per frame for both directions. A rate word K sets the bit period to K/3 system cycles, so the period can be a fraction of a cycle on average.

The host offers transmit words with a valid/ready handshake. The transmitter has a one-entry holding register in front of its shifter. A frame leaves with one stop bit when nothing is waiting behind it. When the next word is already in the holding register before the first stop bit finishes, the frame gets a second stop bit and the next frame follows straight after it. Received words are shown with a valid flag until the host acknowledges them. Each received word carries a framing-error flag, and an overrun flag reports a received word that was lost.

Top module: `uart3_top`

## Requirements
- R1: After synchronous reset, txd is high, tx_ready is high, and rx_valid, rx_frame_err and rx_overrun are low.
- R2: cfg_len selects the data length: 2'b00 gives 7 bits, 2'b01 gives 8 bits, and 2'b10 or 2'b11 gives 9 bits. The transmitter ignores tx_data bits above the selected length, and rx_data bits above it read as zero.
- R3: A transmitted frame is one low start bit, then the data bits least significant first, then a high stop bit. The receiver assembles incoming bits in the same order.
- R4: For K from 16 to 8192, each bit lasts K/3 cycles on average. A run of n bit periods measured from the start of a frame lasts exactly n*K/3 cycles when n*K is a multiple of 3.
- R5: If no word is waiting when the first stop bit ends, the frame has one stop bit. A word accepted right after that point starts its frame within a few cycles, well before a second stop period would have ended.
- R6: If the next word is held before the first stop bit ends, the frame gets two stop bits. The next start bit then begins exactly (n+3) bit periods after the previous start bit, where n is the data length.
- R7: A word is accepted on a cycle with tx_valid and tx_ready both high. tx_ready stays low while the holding register is occupied, and the held word does not change during that time.
- R8: A received word appears on rx_data with rx_valid high. rx_valid stays high until a cycle with rx_ack high.
- R9: The receiver treats a falling edge on rxd as a possible start bit and samples the line again half a bit later. If the line is high at that point, the edge is discarded and no word is produced.
- R10: rx_frame_err is set with a word whose stop bit was sampled low, and is cleared with a word whose stop bit was high. The word is delivered in both cases.
- R11: If a word completes while rx_valid is high and rx_ack is low, rx_overrun goes high and rx_data takes the newer word. rx_ack clears rx_overrun.
- R12: The transmitter and receiver run at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 2 | Data length code (7/8/9 bits) |
| cfg_k | input | 14 | Rate word K; bit period is K/3 cycles |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 9 | Transmit word |
| tx_ready | output | 1 | Holding register free |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| rx_valid | output | 1 | Received word available |
| rx_data | output | 9 | Received word, zero above the data length |
| rx_ack | input | 1 | Host has taken the received word |
| rx_frame_err | output | 1 | Stop bit of the shown word was low |
| rx_overrun | output | 1 | An unread word was replaced |

## Verification
Words of all three lengths are sent through a loopback path with all-ones, all-zero, alternating and mixed patterns. This shows that the length code masks the right bits and that the bit order is correct. All-zero words at several rate words, including fractional ones and both ends of the range, separate an exact K/3 period from an off-by-one count. Pairs of all-ones frames loaded early and late show the difference between two stop bits and one, because the start bits are the only falling edges. Frames driven directly by the bench cover a short low glitch, a low stop bit and two frames with no acknowledge, and a transmission that runs while a frame is being received shows that the two halves are independent.

// File: rtl/uart3_pkg.sv
package uart3_pkg;

    localparam int KW_DEF = 14;
    localparam int DW_DEF = 9;

    typedef enum logic [1:0] {
        LEN_7 = 2'b00,
        LEN_8 = 2'b01,
        LEN_9 = 2'b10
    } len_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP1,
        TX_STOP2
    } tx_st_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_st_e;

    // number of data bits for a length code; 2'b11 falls back to 9
    function automatic logic [3:0] len_bits(input logic [1:0] code);
        case (code)
            LEN_7:   len_bits = 4'd7;
            LEN_8:   len_bits = 4'd8;
            default: len_bits = 4'd9;
        endcase
    endfunction

endpackage

// File: rtl/uart3_rate_gen.sv
module uart3_rate_gen #(
    parameter int KW = uart3_pkg::KW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [KW-1:0] k,
    input  logic          run,
    input  logic [KW:0]   preload,
    output logic          tick
);
    localparam logic [KW:0] STEP = (KW+1)'(3);

    logic [KW:0] acc;
    logic [KW:0] sum;
    logic [KW:0] k_ext;

    assign k_ext = {1'b0, k};
    assign sum   = acc + STEP;
    assign tick  = run && (sum >= k_ext);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (!run) begin
            acc <= preload;
        end else if (tick) begin
            acc <= sum - k_ext;
        end else begin
            acc <= sum;
        end
    end

    AST_ACC_BELOW_K: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $stable(k) && k >= KW'(16)) |-> (acc < k_ext)) // R4
        else $error("accumulator reached the rate word");

endmodule

// File: rtl/uart3_tx.sv
module uart3_tx
    import uart3_pkg::*;
#(
    parameter int KW = KW_DEF,
    parameter int DW = DW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    len,
    input  logic [KW-1:0] k,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic          tx_ready,
    output logic          txd
);
    tx_st_e        state, state_nx;
    logic [DW-1:0] hold_q;
    logic          hold_full;
    logic [DW-1:0] shift_q;
    logic [3:0]    cnt;
    logic [3:0]    nb;
    logic          tick;
    logic          take;
    logic          accept;

    assign nb       = len_bits(len);
    assign tx_ready = !hold_full;
    assign accept   = tx_valid && !hold_full;

    uart3_rate_gen #(.KW(KW)) u_rate (
        .clk     (clk),
        .rst     (rst),
        .k       (k),
        .run     (state != TX_IDLE),
        .preload ('0),
        .tick    (tick)
    );

    always_comb begin
        state_nx = state;
        take     = 1'b0;
        case (state)
            TX_IDLE: if (hold_full) begin
                state_nx = TX_START;
                take     = 1'b1;
            end
            TX_START: if (tick) state_nx = TX_DATA;
            TX_DATA:  if (tick && cnt == nb - 4'd1) state_nx = TX_STOP1;
            TX_STOP1: if (tick) state_nx = hold_full ? TX_STOP2 : TX_IDLE;
            TX_STOP2: if (tick) begin
                state_nx = TX_START;
                take     = 1'b1;
            end
            default:  state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_IDLE;
            hold_q    <= '0;
            hold_full <= 1'b0;
            shift_q   <= '0;
            cnt       <= '0;
        end else begin
            state     <= state_nx;
            hold_full <= (hold_full && !take) || accept;
            if (accept) hold_q <= tx_data;
            if (take) begin
                shift_q <= hold_q;
                cnt     <= '0;
            end else if (state == TX_DATA && tick) begin
                shift_q <= {1'b0, shift_q[DW-1:1]};
                cnt     <= cnt + 4'd1;
            end
        end
    end

    always_comb begin
        case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shift_q[0];
            default:  txd = 1'b1;
        endcase
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready) // R7
        else $error("ready stayed high after accept");

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (hold_full && !take) |=> $stable(hold_q)) // R7
        else $error("held word changed while occupied");

    AST_STOP2_LOADED: assert property (@(posedge clk) disable iff (rst)
        (state == TX_STOP2) |-> hold_full) // R6
        else $error("second stop bit without a waiting word");

endmodule

// File: rtl/uart3_rx.sv
module uart3_rx
    import uart3_pkg::*;
#(
    parameter int KW = KW_DEF,
    parameter int DW = DW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    len,
    input  logic [KW-1:0] k,
    input  logic          rxd,
    input  logic          rx_ack,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          rx_frame_err,
    output logic          rx_overrun
);
    rx_st_e        state;
    logic          s1, s2, s3;
    logic          fall;
    logic          tick;
    logic          done;
    logic [3:0]    cnt;
    logic [3:0]    nb;
    logic [DW-1:0] data_q;

    assign nb   = len_bits(len);
    assign fall = s3 && !s2;
    assign done = (state == RX_STOP) && tick;

    uart3_rate_gen #(.KW(KW)) u_rate (
        .clk     (clk),
        .rst     (rst),
        .k       (k),
        .run     (state != RX_IDLE),
        .preload ({1'b0, k} >> 1),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
            s3 <= s2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            data_q <= '0;
        end else begin
            case (state)
                RX_IDLE: if (fall) begin
                    state  <= RX_START;
                    cnt    <= '0;
                    data_q <= '0;
                end
                RX_START: if (tick) state <= s2 ? RX_IDLE : RX_DATA;
                RX_DATA: if (tick) begin
                    data_q[cnt] <= s2;
                    cnt         <= cnt + 4'd1;
                    if (cnt == nb - 4'd1) state <= RX_STOP;
                end
                RX_STOP: if (tick) state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid     <= 1'b0;
            rx_data      <= '0;
            rx_frame_err <= 1'b0;
            rx_overrun   <= 1'b0;
        end else if (done) begin
            rx_valid     <= 1'b1;
            rx_data      <= data_q;
            rx_frame_err <= !s2;
            rx_overrun   <= rx_valid && !rx_ack;
        end else if (rx_ack) begin
            rx_valid     <= 1'b0;
            rx_overrun   <= 1'b0;
        end
    end

    AST_VALID_HELD: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ack) |=> rx_valid) // R8
        else $error("received word dropped without ack");

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_valid)) // R11
        else $error("overrun without an unread word");

    AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && tick && s2) |=> (state == RX_IDLE && !$rose(rx_valid))) // R9
        else $error("high line at half bit not rejected");

endmodule

// File: rtl/uart3_top.sv
module uart3_top
    import uart3_pkg::*;
#(
    parameter int KW = KW_DEF,
    parameter int DW = DW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cfg_len,
    input  logic [KW-1:0] cfg_k,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic          tx_ready,
    output logic          txd,
    input  logic          rxd,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    input  logic          rx_ack,
    output logic          rx_frame_err,
    output logic          rx_overrun
);

    uart3_tx #(.KW(KW), .DW(DW)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .len      (cfg_len),
        .k        (cfg_k),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .txd      (txd)
    );

    uart3_rx #(.KW(KW), .DW(DW)) u_rx (
        .clk          (clk),
        .rst          (rst),
        .len          (cfg_len),
        .k            (cfg_k),
        .rxd          (rxd),
        .rx_ack       (rx_ack),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_frame_err (rx_frame_err),
        .rx_overrun   (rx_overrun)
    );

endmodule

// File: tb/uart3_top_tb.sv
module uart3_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_len;
    logic [13:0] cfg_k;
    logic        tx_valid;
    logic [8:0]  tx_data;
    logic        tx_ready;
    logic        txd;
    logic        rxd;
    logic        rx_valid;
    logic [8:0]  rx_data;
    logic        rx_ack;
    logic        rx_frame_err;
    logic        rx_overrun;
    logic        loop;
    logic        rxd_drv;
    logic        auto_ack;

    int checks = 0;
    int errors = 0;
    logic [9:0] expq[$];   // {frame_err, data}

    always #5 clk = ~clk;

    assign rxd = loop ? txd : rxd_drv;

    uart3_top u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_len      (cfg_len),
        .cfg_k        (cfg_k),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_ready     (tx_ready),
        .txd          (txd),
        .rxd          (rxd),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_ack       (rx_ack),
        .rx_frame_err (rx_frame_err),
        .rx_overrun   (rx_overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] mask(input logic [8:0] d, input logic [1:0] code);
        case (code)
            2'b00:   mask = d & 9'h07F;
            2'b01:   mask = d & 9'h0FF;
            default: mask = d;
        endcase
    endfunction

    // scoreboard monitor: pops one expected item per received word
    initial begin
        rx_ack = 1'b0;
        forever begin
            @(negedge clk);
            rx_ack = 1'b0;
            if (!rst && auto_ack && rx_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R8 unexpected word", int'(rx_data), 0);
                end else begin
                    logic [9:0] e;
                    e = expq.pop_front();
                    chk({rx_frame_err, rx_data} == e, "R2/R8/R10 received word",
                        int'({rx_frame_err, rx_data}), int'(e));
                end
                rx_ack = 1'b1;
            end
        end
    end

    // driver: offers one word and records what the loopback must return
    task automatic send(input logic [8:0] d, input bit expect_rx);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = d;
        if (expect_rx) expq.push_back({1'b0, mask(d, cfg_len)});
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (expq.size() != 0 && n < 60000) begin
            @(negedge clk);
            n++;
        end
        chk(expq.size() == 0, "R8 scoreboard drained", expq.size(), 0);
        repeat (40) @(negedge clk);
    endtask

    task automatic measure_low(output int c);
        c = 0;
        while (txd !== 1'b0) @(negedge clk);
        while (txd === 1'b0) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic measure_gap(output int c);
        c = 0;
        while (txd !== 1'b0) @(negedge clk);
        while (txd === 1'b0) begin @(negedge clk); c++; end
        while (txd === 1'b1) begin @(negedge clk); c++; end
    endtask

    task automatic sample_tx(input int bc, output logic [7:0] v, output logic stopv);
        while (txd !== 1'b0) @(negedge clk);
        repeat (bc / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (bc) @(negedge clk);
            v[i] = txd;
        end
        repeat (bc) @(negedge clk);
        stopv = txd;
    endtask

    task automatic drive_frame(input logic [8:0] d, input int n, input logic stopv);
        rxd_drv = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rxd_drv = d[i];
            repeat (16) @(negedge clk);
        end
        rxd_drv = stopv;
        repeat (16) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c;
        logic [7:0] v;
        logic sv;
        rst = 1'b1; cfg_len = 2'b01; cfg_k = 14'd48;
        tx_valid = 1'b0; tx_data = '0; loop = 1'b1; rxd_drv = 1'b1; auto_ack = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd && tx_ready && !rx_valid && !rx_frame_err && !rx_overrun, "R1 reset state",
            int'({txd, tx_ready, rx_valid, rx_frame_err, rx_overrun}), 'b11000);

        // R4 bit period: all-zero 8-bit word gives 9 low bit periods
        send(9'h000, 1'b1);
        measure_low(c);
        chk(c == 144, "R4 K=48 nine bits", c, 144);
        drain();
        cfg_k = 14'd50;
        send(9'h000, 1'b1);
        measure_low(c);
        chk(c == 150, "R4 K=50 nine bits", c, 150);
        drain();
        loop = 1'b0;
        cfg_k = 14'd16;
        send(9'h000, 1'b0);
        measure_low(c);
        chk(c == 48, "R4 K=16 nine bits", c, 48);
        repeat (20) @(negedge clk);
        cfg_k = 14'd8192;
        send(9'h000, 1'b0);
        measure_low(c);
        chk(c == 24576, "R4 K=8192 nine bits", c, 24576);
        repeat (4200) @(negedge clk);
        cfg_k = 14'd48;
        loop = 1'b1;
        repeat (20) @(negedge clk);

        // R3 bit order on the line
        fork
            sample_tx(16, v, sv);
            send(9'h0A5, 1'b1);
        join
        chk(v == 8'hA5 && sv, "R3 LSB-first line order", int'({sv, v}), 'h1A5);
        drain();

        // R2 lengths through loopback
        cfg_len = 2'b00;
        send(9'h1FF, 1'b1); send(9'h02A, 1'b1);
        drain();
        cfg_len = 2'b10;
        send(9'h1A5, 1'b1); send(9'h155, 1'b1);
        drain();
        cfg_len = 2'b11;
        send(9'h101, 1'b1);
        drain();
        cfg_len = 2'b01;
        send(9'h13C, 1'b1);
        drain();

        // R6 continuous: second word waiting -> two stop bits
        fork
            measure_gap(c);
            begin
                send(9'h0FF, 1'b1);
                send(9'h0FF, 1'b1);
                @(negedge clk);
                chk(!tx_ready, "R7 ready low while word held", int'(tx_ready), 0);
            end
        join
        chk(c == 176, "R6 start-to-start with two stop bits", c, 176);
        drain();

        // R5 single frame: next word arrives after first stop ended
        fork
            measure_gap(c);
            begin
                send(9'h0FF, 1'b1);
                while (txd !== 1'b0) @(negedge clk);
                repeat (162) @(negedge clk);
                send(9'h0FF, 1'b1);
            end
        join
        chk(c >= 160 && c <= 168, "R5 one stop bit then prompt restart", c, 164);
        drain();

        // R9 glitch rejection
        loop = 1'b0;
        auto_ack = 1'b0;
        rxd_drv = 1'b0;
        repeat (3) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (300) @(negedge clk);
        chk(!rx_valid, "R9 glitch produces no word", int'(rx_valid), 0);
        expq.push_back({1'b0, 9'h05A});
        auto_ack = 1'b1;
        drive_frame(9'h05A, 8, 1'b1);
        drain();

        // R10 framing error
        auto_ack = 1'b0;
        drive_frame(9'h033, 8, 1'b0);
        chk(rx_valid && rx_frame_err && rx_data == 9'h033, "R10 low stop flagged",
            int'({rx_valid, rx_frame_err, rx_data}), 'h633);
        expq.push_back({1'b1, 9'h033});
        auto_ack = 1'b1;
        drain();
        expq.push_back({1'b0, 9'h0C3});
        drive_frame(9'h0C3, 8, 1'b1);
        drain();

        // R11 overrun keeps newer word
        auto_ack = 1'b0;
        drive_frame(9'h011, 8, 1'b1);
        drive_frame(9'h022, 8, 1'b1);
        chk(rx_overrun && rx_data == 9'h022, "R11 overrun keeps newer",
            int'({rx_overrun, rx_data}), 'h222);
        expq.push_back({1'b0, 9'h022});
        auto_ack = 1'b1;
        drain();
        chk(!rx_overrun, "R11 overrun cleared by ack", int'(rx_overrun), 0);

        // R12 transmit and receive at the same time
        expq.push_back({1'b0, 9'h096});
        fork
            drive_frame(9'h096, 8, 1'b1);
            sample_tx(16, v, sv);
            send(9'h00F, 1'b0);
        join
        chk(v == 8'h0F && sv, "R12 transmit during receive", int'({sv, v}), 'h10F);
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule